// File: doc/BRIEF.md
# Main Control Decoder for a Seven-Instruction Load/Store Core

This block turns the 6-bit major opcode and the 6-bit function field of a 32-bit instruction into the control levels for a single-cycle datapath. The instruction subset is register add, register subtract, OR with an immediate, word load, word store, branch-if-equal and unconditional jump. The decoder is purely combinational. One row of AND terms detects each instruction, and an OR row merges those detections into the control outputs.

Each output is the OR of the detectors that need it. Any table entry that would otherwise be left undefined is driven to 0, so every output is known for every input. An input that matches none of the seven detectors produces a quiet state: nothing is written, the fetch path is not redirected, and a flag reports the illegal instruction.

Top module: `ctrl_decode`

## Requirements
- R1: Opcode 000000 selects the register format. Inside that format, function 100000 is add and function 100010 is subtract. The other opcodes are: OR-immediate 001101, load 100011, store 101011, branch-if-equal 000100 and jump 000010. For these six non-register opcodes the function field is ignored.
- R2: `alu_op` is 2'b01 (subtract) for subtract and branch-if-equal, and 2'b10 (OR) for OR-immediate. In every other case it is 2'b00 (add). The value 2'b11 never appears.
- R3: `dst_is_rd` is 1 for add and subtract, which write the rd field at bits 15:11. It is 0 otherwise, which selects the rt field at bits 20:16.
- R4: `opb_is_imm` is 1 for OR-immediate, load and store, which take the extended immediate as the second ALU operand. It is 0 otherwise, which takes the second register.
- R5: `wb_from_mem` is 1 only for load. `dmem_we` is 1 only for store.
- R6: `rf_we` is 1 for add, subtract, OR-immediate and load, and 0 for every other input.
- R7: `br_sel` is 1 only for branch-if-equal. `jmp_sel` is 1 only for jump.
- R8: `imm_sext` is 1 (sign extension) for load and store. It is 0 (zero extension) for OR-immediate and for every other input.
- R9: Every output that R2 to R8 do not set to 1 for an instruction is 0, including the don't-care entries of the table.
- R10: An unlisted opcode, or a register-format word with an unlisted function code, drives `illegal` to 1 and all other outputs to 0. For the seven listed instructions `illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Major opcode, instruction bits 31:26 |
| funct | input | 6 | Function field, instruction bits 5:0 |
| dst_is_rd | output | 1 | Destination register from rd (1) or rt (0) |
| opb_is_imm | output | 1 | Second ALU operand from the immediate (1) or the register (0) |
| wb_from_mem | output | 1 | Write-back value from data memory (1) or the ALU (0) |
| rf_we | output | 1 | Register file write enable |
| dmem_we | output | 1 | Data memory write enable |
| br_sel | output | 1 | Conditional branch selected for the next-PC logic |
| jmp_sel | output | 1 | Jump target selected for the next-PC logic |
| imm_sext | output | 1 | Immediate is sign-extended (1) or zero-extended (0) |
| alu_op | output | 2 | 00 add, 01 subtract, 10 OR |
| illegal | output | 1 | No listed instruction matched |

## Verification
The bench drives all 4096 opcode/function pairs, so the cases most likely to be decoded wrongly are all covered. These are: register-format words with near-miss function codes such as 100001 or 100011, non-register opcodes with a function field that happens to read as add or subtract, and opcodes one bit away from load or store.

Each of these cases catches a specific error. A decoder that ignores the format check would make a jump or branch write the register file. A decoder that leaves don't-care entries floating would assert `dst_is_rd` or `imm_sext` on store or branch. A decoder that matches only part of a field would flag a legal word as illegal, or let an illegal word write memory. A swapped ALU bit would give OR on a branch compare, which the check on `alu_op` for branch-if-equal exposes.

// File: rtl/ctrl_decode.sv
module ctrl_decode (
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output logic       dst_is_rd,
  output logic       opb_is_imm,
  output logic       wb_from_mem,
  output logic       rf_we,
  output logic       dmem_we,
  output logic       br_sel,
  output logic       jmp_sel,
  output logic       imm_sext,
  output logic [1:0] alu_op,
  output logic       illegal
);
  localparam logic [5:0] OP_REG  = 6'b000000;
  localparam logic [5:0] OP_ORI  = 6'b001101;
  localparam logic [5:0] OP_LD   = 6'b100011;
  localparam logic [5:0] OP_ST   = 6'b101011;
  localparam logic [5:0] OP_BEQ  = 6'b000100;
  localparam logic [5:0] OP_JMP  = 6'b000010;
  localparam logic [5:0] FN_ADD  = 6'b100000;
  localparam logic [5:0] FN_SUB  = 6'b100010;

  logic is_reg, hit_add, hit_sub, hit_ori, hit_ld, hit_st, hit_beq, hit_jmp;

  assign is_reg  = (opcode == OP_REG);
  assign hit_add = is_reg && (funct == FN_ADD);
  assign hit_sub = is_reg && (funct == FN_SUB);
  assign hit_ori = (opcode == OP_ORI);
  assign hit_ld  = (opcode == OP_LD);
  assign hit_st  = (opcode == OP_ST);
  assign hit_beq = (opcode == OP_BEQ);
  assign hit_jmp = (opcode == OP_JMP);

  assign dst_is_rd   = hit_add | hit_sub;
  assign opb_is_imm  = hit_ori | hit_ld | hit_st;
  assign wb_from_mem = hit_ld;
  assign rf_we       = hit_add | hit_sub | hit_ori | hit_ld;
  assign dmem_we     = hit_st;
  assign br_sel      = hit_beq;
  assign jmp_sel     = hit_jmp;
  assign imm_sext    = hit_ld | hit_st;
  assign alu_op[0]   = hit_sub | hit_beq;
  assign alu_op[1]   = hit_ori;
  assign illegal     = ~(hit_add | hit_sub | hit_ori | hit_ld | hit_st | hit_beq | hit_jmp);
endmodule

// File: rtl/ctrl_decode_chk.sv
module ctrl_decode_chk (
  input logic [5:0] opcode,
  input logic [5:0] funct,
  input logic       dst_is_rd,
  input logic       opb_is_imm,
  input logic       wb_from_mem,
  input logic       rf_we,
  input logic       dmem_we,
  input logic       br_sel,
  input logic       jmp_sel,
  input logic       imm_sext,
  input logic [1:0] alu_op,
  input logic       illegal
);
  always_comb begin
    // R2
    alu_code_chk: assert (alu_op != 2'b11);
    // R10
    quiet_illegal_chk: assert (!illegal || !(rf_we || dmem_we || br_sel || jmp_sel || alu_op != 2'b00));
    // R6
    one_effect_chk: assert ($onehot0({rf_we, dmem_we, br_sel, jmp_sel}));
    // R5
    load_writes_chk: assert (!wb_from_mem || (rf_we && opb_is_imm && imm_sext));
    // R8
    store_sext_chk: assert (!dmem_we || (opb_is_imm && imm_sext && !dst_is_rd));
    // R7
    branch_sub_chk: assert (!br_sel || (alu_op == 2'b01 && !opb_is_imm));
    // R3
    rd_reg_chk: assert (!dst_is_rd || (opcode == 6'b000000 && rf_we));
    // R1
    nonreg_funct_chk: assert (opcode == 6'b000000 || !dst_is_rd);
    // R10
    legal_flag_chk: assert (illegal != (rf_we || dmem_we || br_sel || jmp_sel));
  end
endmodule

bind ctrl_decode ctrl_decode_chk chk_i (.*);

// File: tb/ctrl_decode_tb.sv
module ctrl_decode_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic [5:0] funct = 6'd0;
  logic dst_is_rd, opb_is_imm, wb_from_mem, rf_we, dmem_we, br_sel, jmp_sel, imm_sext, illegal;
  logic [1:0] alu_op;
  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ctrl_decode dut_i (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete (actual %0d cycles, expected < 20000)", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp, input int op, input int fn);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s op=%b fn=%b: actual %0d expected %0d", tag, op[5:0], fn[5:0], act, exp);
    end
  endtask

  task automatic compare(input int op, input int fn);
    string ins;
    int e_rd = 0, e_imm = 0, e_mem = 0, e_rfw = 0, e_dmw = 0, e_br = 0, e_j = 0, e_sx = 0, e_alu = 0, e_ill = 0;
    // R1 reference instruction recognition
    if (op == 0 && fn == 32) ins = "add";
    else if (op == 0 && fn == 34) ins = "sub";
    else if (op == 13) ins = "ori";
    else if (op == 35) ins = "ld";
    else if (op == 43) ins = "st";
    else if (op == 4) ins = "beq";
    else if (op == 2) ins = "j";
    else ins = "bad";
    case (ins)
      "add": begin e_rd = 1; e_rfw = 1; end
      "sub": begin e_rd = 1; e_rfw = 1; e_alu = 1; end
      "ori": begin e_imm = 1; e_rfw = 1; e_alu = 2; end
      "ld":  begin e_imm = 1; e_mem = 1; e_rfw = 1; e_sx = 1; end
      "st":  begin e_imm = 1; e_dmw = 1; e_sx = 1; end
      "beq": begin e_br = 1; e_alu = 1; end
      "j":   begin e_j = 1; end
      default: e_ill = 1;
    endcase
    check("R2 alu_op", int'(alu_op), e_alu, op, fn);
    check("R3 dst_is_rd", int'(dst_is_rd), e_rd, op, fn);
    check("R4 opb_is_imm", int'(opb_is_imm), e_imm, op, fn);
    check("R5 wb_from_mem", int'(wb_from_mem), e_mem, op, fn);
    check("R5 dmem_we", int'(dmem_we), e_dmw, op, fn);
    check("R6 rf_we", int'(rf_we), e_rfw, op, fn);
    check("R7 br_sel", int'(br_sel), e_br, op, fn);
    check("R7 jmp_sel", int'(jmp_sel), e_j, op, fn);
    check("R8 imm_sext", int'(imm_sext), e_sx, op, fn);
    check("R10 illegal", int'(illegal), e_ill, op, fn);
  endtask

  task automatic apply(input int op, input int fn);
    @(posedge clk);
    opcode = op[5:0];
    funct = fn[5:0];
    @(negedge clk);
    compare(op, fn);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset-time inputs are an unlisted register-format word: quiet and illegal
    compare(0, 0);
    // R1 directed: each instruction, and near misses
    apply(0, 32); apply(0, 34); apply(13, 0); apply(35, 7); apply(43, 63);
    apply(4, 34); apply(2, 32); apply(0, 33); apply(0, 35); apply(34, 0);
    // R9 exhaustive sweep: every don't-care and undefined entry must read 0
    for (int i = 0; i < 4096; i++) apply(i / 64, i % 64);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule